// File: doc/BRIEF.md
# Bank-Matrix RC Knob Scanner

This block reads a matrix of potentiometers without a converter. The knobs are wired as banks by rows. Each bank has a strong select output. Each row has one shared sense line, and each line is an RC node with an open-drain pull-down. To read a knob, the block first drives every bank select low for a deadband. It then raises the select of the wanted bank and pulls all sense lines low to empty the capacitors. Next it releases the lines and counts clock cycles until the synchronized sense level of the wanted row turns high. That count is the raw reading. It is shifted down to a gain code and kept in a register file.

A sweep visits every slot in a fixed order and skips one unused slot. When a new code differs from the stored one, the block writes it and sets a flag that records that the sweep changed something. A sweep starts only when the enable input is high at a sweep boundary. This lets a system hold the knobs still, for example while audio is quiet. The stored codes are presented as one flat vector, slot `s` at bits `[s*CODE_W +: CODE_W]`, where slot = bank*NUM_ROWS + row.

Top module: `knob_scanner`

## Requirements
- R1: After reset every stored code is 0, the changed flag is 0, every bank select is low and no sense line is pulled low.
- R2: Bank selects are always driven. At most one is high at a time. A high select only ever goes back to all-low, never straight to another bank.
- R3: Before each reading, all bank selects stay low for at least DEADBAND_CYC consecutive cycles.
- R4: With the wanted bank selected, all sense lines are pulled low together for exactly DISCHARGE_CYC cycles, then released.
- R5: If the selected row first reads high T cycles after release, with T between 1 and 2^RAW_W-1, the raw count is T. The stored code for that slot becomes T >> (RAW_W-CODE_W), clamped to 2^CODE_W-1.
- R6: If the selected row is already high in the first cycle after release ("fast charge"), the stored code becomes 2^CODE_W-1 (31 by default) and no counting is done.
- R7: If the row has not gone high by the time the count reaches 2^RAW_W-1, the count saturates there, which gives the code for 127 (31 by default).
- R8: Slots are read in increasing slot order: bank 0 rows 0..3, bank 1 rows 0..3, bank 2 rows 0..2, bank 3 rows 0..3. Slot SKIP_SLOT (bank 2 row 3, slot 11 by default) is never selected, and its code stays 0.
- R9: The changed flag clears when a sweep starts. It is set if any reading in that sweep produces a code different from the stored one. A new reading that scales to the same code leaves it clear.
- R10: After the last reading, all bank selects return low and pass_done pulses high for exactly one cycle.
- R11: Enable is sampled only between sweeps. A sweep already started runs to completion. No new sweep starts while enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Allows a new sweep to start |
| sense_in | input | NUM_ROWS | Pad input levels of the sense lines |
| bank_sel | output | NUM_BANKS | Strong bank select outputs, active high |
| sense_drive_low | output | NUM_ROWS | Per-line pull-down enable; the line floats when 0 |
| codes_flat | output | NUM_BANKS*NUM_ROWS*CODE_W | Stored gain codes, slot s at [s*CODE_W +: CODE_W] |
| gain_changed | output | 1 | A code changed during the current or last sweep |
| pass_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds the block with DEADBAND_CYC=5 and DISCHARGE_CYC=3. The raw width, code width, matrix shape and skipped slot keep their defaults. The short waits make a full sweep a few thousand cycles, so eleven sweeps can step the modelled charge time of each read slot across every value from 0 to 164. That range covers fast charge, the codes for counts 1 to 3 (which give 0), every code boundary and the saturated region. Repeat sweeps, and a sweep where one count moves without changing its code, exercise the changed flag. The skipped slot is given an instant charge that would read as 31 if it were ever selected.

// File: rtl/knob_scan_pkg.sv
package knob_scan_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_DEAD,
      SEQ_DRAIN,
      SEQ_MEASURE
   } seq_state_t;

   typedef enum logic [1:0] {
      TMR_IDLE,
      TMR_SETTLE,
      TMR_COUNT
   } tmr_state_t;
endpackage

// File: rtl/knob_sync.sv
module knob_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("knob_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= '0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/knob_timer.sv
module knob_timer
   import knob_scan_pkg::*;
#(
   parameter int RAW_W       = 7,
   parameter int CODE_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              level,
   output logic              done,
   output logic [CODE_W-1:0] code
);
   localparam int               SHIFT    = RAW_W - CODE_W;
   localparam logic [RAW_W-1:0] RAW_MAX  = {RAW_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   generate
      if (RAW_W < CODE_W) begin : g_bad_width
         $error("knob_timer: RAW_W must not be below CODE_W");
      end
      if (SYNC_STAGES >= (1 << RAW_W)) begin : g_bad_sync
         $error("knob_timer: SYNC_STAGES too large for the counter");
      end
   endgenerate

   tmr_state_t       st_q;
   logic [RAW_W-1:0] cnt_q;

   function automatic logic [CODE_W-1:0] scale(input logic [RAW_W-1:0] raw);
      logic [RAW_W-1:0] shifted;
      shifted = raw >> SHIFT;
      if (shifted > RAW_W'(CODE_MAX)) return CODE_MAX;
      else                            return shifted[CODE_W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TMR_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
         code  <= '0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            TMR_IDLE: begin
               if (start) begin
                  st_q  <= TMR_SETTLE;
                  cnt_q <= '0;
               end
            end
            TMR_SETTLE: begin
               if (cnt_q == RAW_W'(SYNC_STAGES)) begin
                  if (level) begin
                     code <= CODE_MAX;
                     done <= 1'b1;
                     st_q <= TMR_IDLE;
                  end else begin
                     cnt_q <= RAW_W'(1);
                     st_q  <= TMR_COUNT;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            TMR_COUNT: begin
               if (level || cnt_q == RAW_MAX) begin
                  code <= scale(cnt_q);
                  done <= 1'b1;
                  st_q <= TMR_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= TMR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/knob_gain_file.sv
module knob_gain_file #(
   parameter int NUM_SLOTS = 16,
   parameter int CODE_W    = 5,
   parameter int SKIP_SLOT = 11,
   parameter int SLOT_W    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_flag,
   input  logic                        wr_en,
   input  logic [SLOT_W-1:0]           wr_slot,
   input  logic [CODE_W-1:0]           wr_code,
   output logic [NUM_SLOTS*CODE_W-1:0] codes_flat,
   output logic                        changed
);
   logic [CODE_W-1:0] cur_code;
   assign cur_code = codes_flat[wr_slot*CODE_W +: CODE_W];

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         if (s == SKIP_SLOT) begin : g_unused
            assign codes_flat[s*CODE_W +: CODE_W] = '0;
         end else begin : g_reg
            logic [CODE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                q <= '0;
               else if (wr_en && wr_slot == SLOT_W'(s))   q <= wr_code;
            end
            assign codes_flat[s*CODE_W +: CODE_W] = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           changed <= 1'b0;
      else if (clr_flag)                    changed <= 1'b0;
      else if (wr_en && wr_code != cur_code) changed <= 1'b1;
   end
endmodule

// File: rtl/knob_scanner.sv
module knob_scanner
   import knob_scan_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int NUM_ROWS      = 4,
   parameter int SKIP_SLOT     = 11,
   parameter int DEADBAND_CYC  = 100,
   parameter int DISCHARGE_CYC = 50,
   parameter int RAW_W         = 7,
   parameter int CODE_W        = 5,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 scan_en,
   input  logic [NUM_ROWS-1:0]                  sense_in,
   output logic [NUM_BANKS-1:0]                 bank_sel,
   output logic [NUM_ROWS-1:0]                  sense_drive_low,
   output logic [NUM_BANKS*NUM_ROWS*CODE_W-1:0] codes_flat,
   output logic                                 gain_changed,
   output logic                                 pass_done
);
   localparam int NUM_SLOTS = NUM_BANKS * NUM_ROWS;
   localparam int ROW_W     = $clog2(NUM_ROWS);
   localparam int SLOT_W    = $clog2(NUM_SLOTS);
   localparam int BANK_W    = SLOT_W - ROW_W;
   localparam int WAIT_MAX  = (DEADBAND_CYC > DISCHARGE_CYC) ? DEADBAND_CYC : DISCHARGE_CYC;
   localparam int CNT_W     = $clog2(WAIT_MAX + 1);
   localparam bit HAS_SKIP  = (SKIP_SLOT >= 0);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   generate
      if (NUM_ROWS < 2 || (1 << ROW_W) != NUM_ROWS) begin : g_bad_rows
         $error("knob_scanner: NUM_ROWS must be a power of two, at least 2");
      end
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("knob_scanner: NUM_BANKS must be a power of two, at least 2");
      end
      if (HAS_SKIP && (SKIP_SLOT == 0 || SKIP_SLOT >= NUM_SLOTS - 1)) begin : g_bad_skip
         $error("knob_scanner: SKIP_SLOT must be -1 or lie strictly inside the sweep");
      end
      if (DEADBAND_CYC < 1 || DISCHARGE_CYC < 1) begin : g_bad_wait
         $error("knob_scanner: wait lengths must be at least 1");
      end
   endgenerate

   seq_state_t        st_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_next;
   logic [CNT_W-1:0]  wait_q;
   logic [BANK_W-1:0] bank_idx;
   logic [ROW_W-1:0]  row_idx;
   logic [NUM_ROWS-1:0] sense_sync;
   logic              tmr_start;
   logic              tmr_done;
   logic [CODE_W-1:0] tmr_code;
   logic              sweep_start;

   assign bank_idx    = slot_q[SLOT_W-1:ROW_W];
   assign row_idx     = slot_q[ROW_W-1:0];
   assign sweep_start = (st_q == SEQ_IDLE) && scan_en;
   assign tmr_start   = (st_q == SEQ_DRAIN) && (wait_q == CNT_W'(DISCHARGE_CYC - 1));

   always_comb begin
      slot_next = slot_q + 1'b1;
      if (HAS_SKIP && slot_next == SLOT_W'(SKIP_SLOT)) slot_next = slot_q + SLOT_W'(2);
   end

   always_comb begin
      bank_sel = '0;
      if (st_q == SEQ_DRAIN || st_q == SEQ_MEASURE) bank_sel = NUM_BANKS'(1) << bank_idx;
      sense_drive_low = (st_q == SEQ_DRAIN) ? '1 : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SEQ_IDLE;
         slot_q    <= '0;
         wait_q    <= '0;
         pass_done <= 1'b0;
      end else begin
         pass_done <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: begin
               if (scan_en) begin
                  st_q   <= SEQ_DEAD;
                  slot_q <= '0;
                  wait_q <= '0;
               end
            end
            SEQ_DEAD: begin
               if (wait_q == CNT_W'(DEADBAND_CYC - 1)) begin
                  st_q   <= SEQ_DRAIN;
                  wait_q <= '0;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            SEQ_DRAIN: begin
               if (tmr_start) begin
                  st_q   <= SEQ_MEASURE;
                  wait_q <= '0;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            SEQ_MEASURE: begin
               if (tmr_done) begin
                  if (slot_q == LAST_SLOT) begin
                     st_q      <= SEQ_IDLE;
                     pass_done <= 1'b1;
                  end else begin
                     st_q   <= SEQ_DEAD;
                     slot_q <= slot_next;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   knob_sync #(
      .WIDTH (NUM_ROWS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(sense_in),
      .q_sync (sense_sync)
   );

   knob_timer #(
      .RAW_W      (RAW_W),
      .CODE_W     (CODE_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(tmr_start),
      .level(sense_sync[row_idx]),
      .done (tmr_done),
      .code (tmr_code)
   );

   knob_gain_file #(
      .NUM_SLOTS(NUM_SLOTS),
      .CODE_W   (CODE_W),
      .SKIP_SLOT(SKIP_SLOT),
      .SLOT_W   (SLOT_W)
   ) u_gains (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_flag  (sweep_start),
      .wr_en     (tmr_done),
      .wr_slot   (slot_q),
      .wr_code   (tmr_code),
      .codes_flat(codes_flat),
      .changed   (gain_changed)
   );
endmodule

// File: rtl/knob_scanner_chk.sv
module knob_scanner_chk #(
   parameter int NUM_BANKS    = 4,
   parameter int NUM_ROWS     = 4,
   parameter int CODE_W       = 5,
   parameter int DEADBAND_CYC = 100
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic [NUM_BANKS-1:0]                 bank_sel,
   input logic [NUM_ROWS-1:0]                  sense_drive_low,
   input logic [NUM_BANKS*NUM_ROWS*CODE_W-1:0] codes_flat,
   input logic                                 gain_changed,
   input logic                                 pass_done
);
   logic [15:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_run <= '0;
      else if (|bank_sel)      low_run <= '0;
      else if (low_run != '1)  low_run <= low_run + 1'b1;
   end

   assert_onehot_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel));

   assert_bank_via_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_sel) |=> (bank_sel == $past(bank_sel) || bank_sel == '0));

   assert_deadband_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|bank_sel) |-> (low_run >= 16'(DEADBAND_CYC)));

   assert_drain_all_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|sense_drive_low) |-> ((&sense_drive_low) && (|bank_sel)));

   assert_codes_hold_in_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|sense_drive_low) |=> $stable(codes_flat));

   assert_flag_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gain_changed) |-> (codes_flat != $past(codes_flat)));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

   assert_done_banks_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> (bank_sel == '0));
endmodule

bind knob_scanner knob_scanner_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .NUM_ROWS    (NUM_ROWS),
   .CODE_W      (CODE_W),
   .DEADBAND_CYC(DEADBAND_CYC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bank_sel       (bank_sel),
   .sense_drive_low(sense_drive_low),
   .codes_flat     (codes_flat),
   .gain_changed   (gain_changed),
   .pass_done      (pass_done)
);

// File: tb/knob_scanner_bench.sv
module knob_scanner_bench;
   localparam int NB   = 4;
   localparam int NR   = 4;
   localparam int NS   = NB * NR;
   localparam int CW   = 5;
   localparam int DB   = 5;
   localparam int DC   = 3;
   localparam int SKIP = 11;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic               rst_n;
   logic               scan_en;
   logic [NR-1:0]      sense_in;
   logic [NB-1:0]      bank_sel;
   logic [NR-1:0]      drv;
   logic [NS*CW-1:0]   codes;
   logic               changed;
   logic               done;

   knob_scanner #(
      .DEADBAND_CYC (DB),
      .DISCHARGE_CYC(DC)
   ) u_knob_scanner (
      .clk            (clk),
      .rst_n          (rst_n),
      .scan_en        (scan_en),
      .sense_in       (sense_in),
      .bank_sel       (bank_sel),
      .sense_drive_low(drv),
      .codes_flat     (codes),
      .gain_changed   (changed),
      .pass_done      (done)
   );

   int nchk = 0;
   int nfail = 0;
   int tchg [NS];
   int rel_cnt = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_code(input int t);
      int r;
      if (t == 0) return 31;
      r = (t > 127) ? 127 : t;
      return r >> 2;
   endfunction

   function automatic int slot_of(input int i);
      return (i < SKIP) ? i : i + 1;
   endfunction

   // RC node model: line rises T cycles after release, only for the selected bank
   always_ff @(posedge clk) begin
      if (|drv)                 rel_cnt <= 0;
      else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
   end

   always_comb begin
      int b;
      b = 0;
      for (int k = 0; k < NB; k++) if (bank_sel[k]) b = k;
      for (int r = 0; r < NR; r++)
         sense_in[r] = !drv[r] && (|bank_sel) && (rel_cnt >= tchg[b*NR + r]);
   end

   // port monitors
   int zrun = 1000;
   int drun = 0;
   int dnrun = 0;
   int rises = 0;
   int seq_idx = 0;
   int dones = 0;
   logic [NB-1:0] last_bank = '0;
   logic [NR-1:0] last_drv = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (last_bank == '0 && bank_sel != '0) begin
            int eb;
            int ab;
            ab = 0;
            for (int k = 0; k < NB; k++) if (bank_sel[k]) ab = k;
            eb = slot_of(seq_idx) / NR;
            chk(zrun >= DB, "R3 deadband", zrun, DB);
            chk($countones(bank_sel) == 1 && ab == eb, "R8 bank order", ab, eb);
            seq_idx++;
            rises++;
         end
         if (last_bank != '0 && bank_sel != '0 && bank_sel != last_bank)
            chk(0, "R2 direct bank switch", int'(bank_sel), 0);
         if (last_drv != '0 && drv == '0)
            chk(drun == DC && last_drv == '1, "R4 drain length", drun, DC);
         if (last_drv == '0 && drv != '0)
            chk(bank_sel != '0 && drv == '1, "R4 drain with bank", int'(drv), 15);
         if (!done && dnrun != 0) begin
            chk(dnrun == 1, "R10 pulse width", dnrun, 1);
         end
         if (done) begin
            if (dnrun == 0) dones++;
            chk(bank_sel == '0, "R10 banks off", int'(bank_sel), 0);
         end
      end
      dnrun     = done ? dnrun + 1 : 0;
      zrun      = (bank_sel == '0) ? zrun + 1 : 0;
      drun      = (drv != '0) ? drun + 1 : 0;
      last_bank = bank_sel;
      last_drv  = drv;
   end

   int prev_exp [NS];

   task automatic run_pass(input string tag);
      int d0;
      bit exp_chg;
      d0 = dones;
      seq_idx = 0;
      scan_en = 1'b1;
      do @(negedge clk); while (bank_sel == '0);
      scan_en = 1'b0;
      do @(negedge clk); while (dones == d0);
      @(negedge clk);
      chk(seq_idx == NS - 1, "R8 reads per sweep", seq_idx, NS - 1);
      chk(dones == d0 + 1, "R10 one done per sweep", dones - d0, 1);
      exp_chg = 1'b0;
      for (int s = 0; s < NS; s++) begin
         int e;
         int a;
         e = (s == SKIP) ? 0 : exp_code(tchg[s]);
         a = int'(codes[s*CW +: CW]);
         if (s == SKIP)                 chk(a == e, "R8 skipped slot", a, e);
         else if (tchg[s] == 0)          chk(a == e, "R6 fast charge", a, e);
         else if (tchg[s] >= 127)        chk(a == e, "R7 saturation", a, e);
         else                            chk(a == e, "R5 scaled code", a, e);
         if (e != prev_exp[s]) exp_chg = 1'b1;
         prev_exp[s] = e;
      end
      chk(changed == exp_chg, {"R9 changed flag ", tag}, int'(changed), int'(exp_chg));
   endtask

   initial begin
      #(4 * 150000);
      chk(0, "R10 watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      scan_en = 1'b0;
      for (int s = 0; s < NS; s++) begin
         tchg[s] = 50;
         prev_exp[s] = 0;
      end
      repeat (4) @(negedge clk);
      chk(bank_sel == '0 && drv == '0, "R1 outputs in reset", int'({bank_sel, drv}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(codes == '0, "R1 codes after reset", int'(codes[31:0]), 0);
      chk(changed == 1'b0, "R1 flag after reset", int'(changed), 0);
      chk(bank_sel == '0 && drv == '0, "R11 idle without enable", int'({bank_sel, drv}), 0);

      // sweep charge times 0..164 across the read slots
      for (int p = 0; p < 11; p++) begin
         for (int i = 0; i < NS - 1; i++) tchg[slot_of(i)] = p * 15 + i;
         tchg[SKIP] = 0;
         run_pass("sweep");
      end

      // identical sweep: nothing changes
      run_pass("repeat");

      // count moves inside one code bucket: still no change
      for (int i = 0; i < NS - 1; i++) tchg[slot_of(i)] = 40 + 4 * (i % 5);
      run_pass("set");
      for (int i = 0; i < NS - 1; i++) tchg[slot_of(i)] = 41 + 4 * (i % 5);
      run_pass("same bucket");

      // R11: enable low keeps the scanner idle
      begin
         int r0;
         r0 = rises;
         repeat (600) @(negedge clk);
         chk(rises == r0, "R11 no sweep while disabled", rises - r0, 0);
         chk(bank_sel == '0 && drv == '0, "R11 lines quiet", int'({bank_sel, drv}), 0);
      end

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule